// File: doc/BRIEF.md
# Banked Interrupt CPU-Interface Register File

This block is the register file of one processor's interrupt interface. The processor reaches it over a simple register bus. Each access carries a flag that marks it as secure or non-secure. The block holds the control word, the priority mask, the binary point and its aliased copy. It answers running-priority, highest-pending and acknowledge reads, and it takes end-of-interrupt writes. A secure access and a non-secure access do not see two separate copies. They see two views of one stored value. The non-secure view may be shifted, it may be limited to a few bits, or it may be hidden.

An arbiter outside the block chooses the highest-priority pending interrupt. It presents that interrupt as an ID, a group bit, a priority and a valid flag. The block tracks one active interrupt and a single running priority; there is no preemption stack. The running priority sits at 0x100 (idle) until an acknowledge succeeds. A matching end-of-interrupt returns it to idle.

Two parameters select the configuration. `HAS_SEC` enables the security extensions. `REV2` selects the second revision of the register layout. With `HAS_SEC` = 0, every access is treated as secure. Interrupt groups exist when either parameter is 1. Register select is `bus_addr[4:2]`:
- 0x00: control
- 0x04: priority mask
- 0x08: binary point
- 0x0C: acknowledge
- 0x10: end of interrupt
- 0x14: running priority
- 0x18: highest pending
- 0x1C: aliased binary point

Top module: `banked_cpuif_regs`

## Requirements
- R1: After reset the stored values are:
  - control 0
  - priority mask 0
  - binary point 0
  - aliased binary point 1
  - running priority 0x100

  No read is valid in the first cycle after reset.
- R2: A secure control write stores the written value ANDed with a mask set by the configuration:
  - 0x61F with HAS_SEC=1, REV2=1
  - 0x21F with HAS_SEC=0, REV2=1
  - 0x1F with HAS_SEC=1, REV2=0
  - 0x1 with HAS_SEC=0, REV2=0

  A secure control read returns the stored word.
- R3: A non-secure control read returns stored bits 1 and 10, each moved down one place, so the result holds them in bits 0 and 9. A non-secure control write copies written bit 0 to stored bit 1. With REV2=1 it also copies written bit 9 to stored bit 10. All other stored bits are left unchanged.
- R4: A non-secure priority-mask access depends on stored mask bit 7:
  - With bit 7 set, a read returns (mask << 1) & 0xFF, and a write stores 0x80 | (value[7:0] >> 1).
  - With bit 7 clear, a read returns 0 and a write is ignored.

  Secure accesses read and write the 8-bit mask directly.
- R5: A secure running-priority read returns the 9-bit running priority. A non-secure read returns (running << 1) & 0xFF when running bit 7 is set, and 0 otherwise.
- R6: The binary point at 0x08 is banked. A secure access uses the primary 3-bit copy and stores the value unchanged. A non-secure access uses the aliased copy, and a written value below 1 is raised to 1.
- R7: A read at 0x1C returns 0, and a write there is ignored, when the access is non-secure or the configuration has no groups. Otherwise the address reaches the aliased copy, with the minimum of 1 applied.
- R8: A highest-pending read returns the first matching case:
  - 1023 when no interrupt is pending
  - 1023 for a group 0 interrupt on a non-secure access
  - 1022 for a group 1 interrupt on a secure access with control bit 2 (AckCtl) clear
  - the pending ID otherwise

  The hidden codes apply only when groups exist.
- R9: An acknowledge read returns the same hidden codes as R8, and then changes nothing. Otherwise:
  - If the pending priority is not below the running priority, it returns 1023 and changes nothing.
  - If it is below, it returns the ID, makes that interrupt active and sets the running priority to the pending priority.
- R10: An end-of-interrupt write takes the ID from bits [9:0] of the written value. The running priority returns to 0x100 only when that ID equals the active ID. A non-secure write for an active group 0 interrupt is ignored.
- R11: With HAS_SEC=0, the secure flag has no effect: every access uses the secure view.
- R12: Read data is valid in the cycle after the request. A read of the write-only end-of-interrupt address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 1 | Access is secure |
| pend_valid | input | 1 | An interrupt is pending |
| pend_id | input | 10 | ID of the highest pending interrupt |
| pend_grp | input | 1 | Group of the pending interrupt |
| pend_prio | input | 8 | Priority of the pending interrupt |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ack_pulse | output | 1 | An interrupt became active |
| ack_id | output | 10 | ID that became active |
| eoi_pulse | output | 1 | The active interrupt completed |
| eoi_id | output | 10 | ID that completed |
| run_prio | output | 9 | Current running priority (0x100 = idle) |

## Verification
The assertions take two things for granted:
- A request lasts a single cycle.
- The pending inputs hold steady during the cycle of an acknowledge request, so the activation they observe matches the value read.

The bench drives each request for exactly one clock and changes the pending inputs only between requests. It sweeps:
- every priority-mask value through both views
- every binary-point value through both banks
- every combination of group, security flag and AckCtl for the pending codes

A second instance with no security extension and the first revision covers the reduced control mask and the no-groups case.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;
    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;
    localparam int RUN_W  = PRIO_W + 1;
    localparam int CTRL_W = 11;
    localparam int BP_W   = 3;

    localparam logic [ID_W-1:0]   ID_SPURIOUS = {ID_W{1'b1}};
    localparam logic [ID_W-1:0]   ID_HIDDEN   = ID_SPURIOUS - 1'b1;
    localparam logic [RUN_W-1:0]  RUN_IDLE    = {1'b1, {PRIO_W{1'b0}}};
    localparam logic [BP_W-1:0]   ABP_MIN     = 3'd1;

    // control word bit positions
    localparam int CB_EN0    = 0;
    localparam int CB_EN1    = 1;
    localparam int CB_ACK    = 2;
    localparam int CB_FIQ    = 3;
    localparam int CB_CBP    = 4;
    localparam int CB_EOIM   = 9;
    localparam int CB_EOIMNS = 10;

    typedef enum logic [2:0] {
        SEL_CTRL  = 3'd0,
        SEL_PMASK = 3'd1,
        SEL_BP    = 3'd2,
        SEL_ACK   = 3'd3,
        SEL_EOI   = 3'd4,
        SEL_RUN   = 3'd5,
        SEL_HPEND = 3'd6,
        SEL_ABP   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [PRIO_W-1:0] pmask;
        logic [BP_W-1:0]   bp;
        logic [BP_W-1:0]   abp;
        logic [RUN_W-1:0]  run;
        logic              act_v;
        logic [ID_W-1:0]   act_id;
        logic              act_grp;
        logic              rd_v;
        logic [DATA_W-1:0] rd_data;
        logic              ack_p;
        logic [ID_W-1:0]   ack_id;
        logic              eoi_p;
        logic [ID_W-1:0]   eoi_id;
    } cpuif_state_t;

    function automatic logic [CTRL_W-1:0] secure_ctrl_mask(input bit rev2, input bit has_sec);
        logic [CTRL_W-1:0] m;
        m = '0;
        m[CB_EN0] = 1'b1;
        if (has_sec) begin
            m[CB_EN1] = 1'b1;
            m[CB_ACK] = 1'b1;
            m[CB_FIQ] = 1'b1;
            m[CB_CBP] = 1'b1;
        end
        if (rev2) begin
            m[CB_EN1]  = 1'b1;
            m[CB_ACK]  = 1'b1;
            m[CB_FIQ]  = 1'b1;
            m[CB_CBP]  = 1'b1;
            m[CB_EOIM] = 1'b1;
            if (has_sec) m[CB_EOIMNS] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [CTRL_W-1:0] nonsecure_ctrl_mask(input bit rev2);
        logic [CTRL_W-1:0] m;
        m = '0;
        m[CB_EN1] = 1'b1;
        if (rev2) m[CB_EOIMNS] = 1'b1;
        return m;
    endfunction

    function automatic logic [BP_W-1:0] clamp_bp(input logic [BP_W-1:0] v,
                                                 input logic [BP_W-1:0] lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/cpuif_prio_view.sv
// Non-secure view of a priority-like value: visible only when the value
// lies in the upper half of the range, then shown doubled.
module cpuif_prio_view #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] stored,
    output logic [PW-1:0] ns_view
);
    always_comb begin
        if (stored[PW-1]) ns_view = {stored[PW-2:0], 1'b0};
        else              ns_view = '0;
    end
endmodule

// File: rtl/cpuif_pend_code.sv
// Turns the arbiter's pending interrupt into the code one access may see.
module cpuif_pend_code
    import cpuif_pkg::*;
#(
    parameter bit GROUPS = 1'b1
) (
    input  logic            pend_valid,
    input  logic [ID_W-1:0] pend_id,
    input  logic            pend_grp,
    input  logic            secure,
    input  logic            ack_ctl,
    output logic [ID_W-1:0] code,
    output logic            visible
);
    logic hide_g0;
    logic hide_g1;

    generate
        if (GROUPS) begin : g_grp
            assign hide_g0 = !pend_grp && !secure;
            assign hide_g1 = pend_grp && secure && !ack_ctl;
        end else begin : g_nogrp
            assign hide_g0 = 1'b0;
            assign hide_g1 = 1'b0;
        end
    endgenerate

    always_comb begin
        visible = 1'b0;
        if (!pend_valid)  code = ID_SPURIOUS;
        else if (hide_g0) code = ID_SPURIOUS;
        else if (hide_g1) code = ID_HIDDEN;
        else begin
            code    = pend_id;
            visible = 1'b1;
        end
    end
endmodule

// File: rtl/banked_cpuif_regs.sv
module banked_cpuif_regs
    import cpuif_pkg::*;
#(
    parameter bit HAS_SEC = 1'b1,
    parameter bit REV2    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_sec,
    input  logic              pend_valid,
    input  logic [ID_W-1:0]   pend_id,
    input  logic              pend_grp,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ack_pulse,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_pulse,
    output logic [ID_W-1:0]   eoi_id,
    output logic [RUN_W-1:0]  run_prio
);
    localparam bit                GROUPS   = HAS_SEC || REV2;
    localparam logic [CTRL_W-1:0] S_MASK   = secure_ctrl_mask(REV2, HAS_SEC);
    localparam logic [CTRL_W-1:0] NS_MASK  = nonsecure_ctrl_mask(REV2);

    cpuif_state_t q, d;

    logic                     secure;
    reg_sel_e                 sel;
    logic [ID_W-1:0]          pcode;
    logic                     pvis;
    logic [PRIO_W-1:0]        pmask_ns;
    logic [PRIO_W-1:0]        run_ns;
    logic [CTRL_W-1:0]        ctrl_ns;
    logic [CTRL_W-1:0]        ctrl_ns_wr;
    logic [ID_W-1:0]          eoi_req_id;
    logic                     unused_bits;

    assign secure      = !HAS_SEC || bus_sec;
    assign sel         = reg_sel_e'(bus_addr[4:2]);
    assign eoi_req_id  = bus_wdata[ID_W-1:0];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CTRL_W]};

    assign ctrl_ns     = (q.ctrl & NS_MASK) >> 1;
    assign ctrl_ns_wr  = (q.ctrl & ~NS_MASK) | ((bus_wdata[CTRL_W-1:0] << 1) & NS_MASK);

    cpuif_pend_code #(.GROUPS(GROUPS)) pend_code_i (
        .pend_valid (pend_valid),
        .pend_id    (pend_id),
        .pend_grp   (pend_grp),
        .secure     (secure),
        .ack_ctl    (q.ctrl[CB_ACK]),
        .code       (pcode),
        .visible    (pvis)
    );

    cpuif_prio_view #(.PW(PRIO_W)) mask_view_i (
        .stored  (q.pmask),
        .ns_view (pmask_ns)
    );

    cpuif_prio_view #(.PW(PRIO_W)) run_view_i (
        .stored  (q.run[PRIO_W-1:0]),
        .ns_view (run_ns)
    );

    // next-state logic
    always_comb begin
        d         = q;
        d.rd_v    = 1'b0;
        d.rd_data = '0;
        d.ack_p   = 1'b0;
        d.eoi_p   = 1'b0;
        if (bus_req && !bus_wr) begin
            d.rd_v = 1'b1;
            unique case (sel)
                SEL_CTRL:  d.rd_data = DATA_W'(secure ? q.ctrl : ctrl_ns);
                SEL_PMASK: d.rd_data = DATA_W'(secure ? q.pmask : pmask_ns);
                SEL_BP:    d.rd_data = DATA_W'(secure ? q.bp : q.abp);
                SEL_ACK: begin
                    if (!pvis) begin
                        d.rd_data = DATA_W'(pcode);
                    end else if ({1'b0, pend_prio} < q.run) begin
                        d.rd_data = DATA_W'(pcode);
                        d.run     = {1'b0, pend_prio};
                        d.act_v   = 1'b1;
                        d.act_id  = pend_id;
                        d.act_grp = pend_grp;
                        d.ack_p   = 1'b1;
                        d.ack_id  = pend_id;
                    end else begin
                        d.rd_data = DATA_W'(ID_SPURIOUS);
                    end
                end
                SEL_EOI:   d.rd_data = '0;
                SEL_RUN:   d.rd_data = DATA_W'(secure ? q.run : {1'b0, run_ns});
                SEL_HPEND: d.rd_data = DATA_W'(pcode);
                SEL_ABP:   d.rd_data = DATA_W'((GROUPS && secure) ? q.abp : '0);
                default:   d.rd_data = '0;
            endcase
        end else if (bus_req && bus_wr) begin
            unique case (sel)
                SEL_CTRL: begin
                    if (secure) d.ctrl = bus_wdata[CTRL_W-1:0] & S_MASK;
                    else        d.ctrl = ctrl_ns_wr;
                end
                SEL_PMASK: begin
                    if (secure)          d.pmask = bus_wdata[PRIO_W-1:0];
                    else if (q.pmask[7]) d.pmask = {1'b1, bus_wdata[PRIO_W-1:1]};
                end
                SEL_BP: begin
                    if (secure) d.bp  = bus_wdata[BP_W-1:0];
                    else        d.abp = clamp_bp(bus_wdata[BP_W-1:0], ABP_MIN);
                end
                SEL_EOI: begin
                    if (q.act_v && (eoi_req_id == q.act_id) &&
                        !(!secure && GROUPS && !q.act_grp)) begin
                        d.act_v  = 1'b0;
                        d.run    = RUN_IDLE;
                        d.eoi_p  = 1'b1;
                        d.eoi_id = eoi_req_id;
                    end
                end
                SEL_ABP: begin
                    if (GROUPS && secure) d.abp = clamp_bp(bus_wdata[BP_W-1:0], ABP_MIN);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.abp     <= ABP_MIN;
            q.run     <= RUN_IDLE;
            q.act_id  <= ID_SPURIOUS;
        end else begin
            q <= d;
        end
    end

    assign rd_valid  = q.rd_v;
    assign rd_data   = q.rd_data;
    assign ack_pulse = q.ack_p;
    assign ack_id    = q.ack_id;
    assign eoi_pulse = q.eoi_p;
    assign eoi_id    = q.eoi_id;
    assign run_prio  = q.run;

    // R3
    ns_ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && sel == SEL_CTRL && !secure)
        |=> (q.ctrl[CB_EN0] == $past(q.ctrl[CB_EN0])));

    // R4
    ns_pmask_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && sel == SEL_PMASK && !secure && !q.pmask[7])
        |=> $stable(q.pmask));

    // R6
    abp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.abp >= ABP_MIN);

    // R9
    ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_pulse |-> (run_prio < $past(run_prio)));

    // R10
    eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_pulse |-> (run_prio == RUN_IDLE && $past(run_prio) != RUN_IDLE));

    // R12
    rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr) |=> rd_valid);

endmodule

// File: tb/banked_cpuif_regs_tb_top.sv
module banked_cpuif_regs_tb_top;
    import cpuif_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              bus_req = 0, bus_wr = 0, bus_sec = 0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              pend_valid = 0, pend_grp = 0;
    logic [ID_W-1:0]   pend_id = '0;
    logic [PRIO_W-1:0] pend_prio = '0;

    logic              rv_a, rv_b, ap_a, ap_b, ep_a, ep_b;
    logic [DATA_W-1:0] rd_a, rd_b;
    logic [ID_W-1:0]   ai_a, ai_b, ei_a, ei_b;
    logic [RUN_W-1:0]  rp_a, rp_b;

    banked_cpuif_regs #(.HAS_SEC(1'b1), .REV2(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sec(bus_sec),
        .pend_valid(pend_valid), .pend_id(pend_id), .pend_grp(pend_grp),
        .pend_prio(pend_prio), .rd_valid(rv_a), .rd_data(rd_a),
        .ack_pulse(ap_a), .ack_id(ai_a), .eoi_pulse(ep_a), .eoi_id(ei_a),
        .run_prio(rp_a));

    banked_cpuif_regs #(.HAS_SEC(1'b0), .REV2(1'b0)) dut_nosec_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sec(bus_sec),
        .pend_valid(pend_valid), .pend_id(pend_id), .pend_grp(pend_grp),
        .pend_prio(pend_prio), .rd_valid(rv_b), .rd_data(rd_b),
        .ack_pulse(ap_b), .ack_id(ai_b), .eoi_pulse(ep_b), .eoi_id(ei_b),
        .run_prio(rp_b));

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DATA_W-1:0] got_a, got_b;
    logic              got_v;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [7:0] off, input logic [31:0] data, input logic s);
        @(negedge clk);
        bus_req = 1; bus_wr = w; bus_addr = off[4:0]; bus_wdata = data; bus_sec = s;
        @(negedge clk);
        bus_req = 0; bus_wr = 0;
        got_a = rd_a; got_b = rd_b; got_v = rv_a;
    endtask

    task automatic wr(input logic [7:0] off, input logic [31:0] data, input logic s);
        acc(1'b1, off, data, s);
    endtask

    task automatic rd(input logic [7:0] off, input logic s);
        acc(1'b0, off, 32'h0, s);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk("R1 rd_valid idle", {31'h0, rv_a}, 32'h0);
        chk("R1 run_prio", {23'h0, rp_a}, 32'h100);
        rd(8'h00, 1); chk("R1 ctrl", got_a, 32'h0);
        rd(8'h04, 1); chk("R1 pmask", got_a, 32'h0);
        rd(8'h08, 1); chk("R1 bp", got_a, 32'h0);
        rd(8'h1C, 1); chk("R1 abp", got_a, 32'h1);
        chk("R12 rd_valid", {31'h0, got_v}, 32'h1);
        rd(8'h10, 1); chk("R12 eoi reads zero", got_a, 32'h0);

        // R2 secure control masks
        wr(8'h00, 32'hFFFF_FFFF, 1);
        rd(8'h00, 1);
        chk("R2 ctrl mask sec rev2", got_a, 32'h61F);
        chk("R2 ctrl mask nosec rev1", got_b, 32'h1);
        // R3 non-secure control view
        rd(8'h00, 0); chk("R3 ns ctrl read", got_a, 32'h201);
        wr(8'h00, 32'h0, 0);
        rd(8'h00, 1); chk("R3 ns ctrl clear", got_a, 32'h61F & ~32'h402);
        wr(8'h00, 32'hFFFF_FDFE, 0);
        rd(8'h00, 1); chk("R3 ns ctrl keep", got_a, 32'h21D);
        wr(8'h00, 32'h201, 0);
        rd(8'h00, 1); chk("R3 ns ctrl set", got_a, 32'h61F);
        // R11 no-security instance treats ns write as secure
        wr(8'h00, 32'h0, 0);
        rd(8'h00, 0); chk("R11 nosec ctrl write", got_b, 32'h0);
        wr(8'h00, 32'h1, 0);
        rd(8'h00, 0); chk("R11 nosec ctrl ns read", got_b, 32'h1);

        // R4 priority mask views, full sweep
        for (int v = 0; v < 256; v++) begin
            wr(8'h04, v, 1);
            rd(8'h04, 0);
            chk("R4 ns pmask read", got_a, (v & 8'h80) ? ((v << 1) & 32'hFF) : 32'h0);
            chk("R11 nosec pmask", got_b, v);
            wr(8'h04, 32'h80, 1);
            wr(8'h04, v, 0);
            rd(8'h04, 1);
            chk("R4 ns pmask write", got_a, 32'h80 | (v >> 1));
        end
        for (int v = 0; v < 256; v += 37) begin
            wr(8'h04, 32'h7F, 1);
            wr(8'h04, v, 0);
            rd(8'h04, 1);
            chk("R4 ns pmask ignored", got_a, 32'h7F);
        end

        // R6 / R7 binary points
        for (int v = 0; v < 8; v++) begin
            wr(8'h08, v, 1);
            rd(8'h08, 1); chk("R6 sec bp", got_a, v);
            wr(8'h08, v, 0);
            rd(8'h08, 0); chk("R6 ns bp clamp", got_a, (v < 1) ? 1 : v);
            rd(8'h1C, 1); chk("R7 abp alias read", got_a, (v < 1) ? 1 : v);
            rd(8'h1C, 0); chk("R7 abp ns raz", got_a, 32'h0);
            wr(8'h1C, 7 - v, 1);
            rd(8'h08, 0); chk("R7 abp alias write", got_a, (7 - v < 1) ? 1 : 7 - v);
            wr(8'h1C, 32'h5, 0);
            rd(8'h08, 0); chk("R7 abp ns wi", got_a, (7 - v < 1) ? 1 : 7 - v);
            wr(8'h1C, 32'h5, 1);
            rd(8'h1C, 1); chk("R7 nogroup raz", got_b, 32'h0);
        end
        wr(8'h08, 32'h0, 0);
        rd(8'h08, 1); chk("R11 nosec bp min0", got_b, 32'h0);

        // R8 highest pending codes
        rd(8'h18, 1); chk("R8 none pending", got_a, 32'd1023);
        pend_valid = 1; pend_id = 10'd37; pend_prio = 8'h40;
        for (int g = 0; g < 2; g++)
            for (int s = 0; s < 2; s++)
                for (int a = 0; a < 2; a++) begin
                    wr(8'h00, a ? 32'h7 : 32'h3, 1);
                    pend_grp = g[0];
                    rd(8'h18, s[0]);
                    chk("R8 hpend code", got_a,
                        (g == 0 && s == 0) ? 32'd1023 :
                        (g == 1 && s == 1 && a == 0) ? 32'd1022 : 32'd37);
                    chk("R11 nosec hpend", got_b, 32'd37);
                end

        // R9 acknowledge
        wr(8'h00, 32'h3, 1);
        pend_grp = 1; rd(8'h0C, 1);
        chk("R9 ack hidden", got_a, 32'd1022);
        rd(8'h14, 1); chk("R9 hidden leaves run", got_a, 32'h100);
        pend_grp = 0; pend_id = 10'd5; pend_prio = 8'h40;
        rd(8'h0C, 1); chk("R9 ack id", got_a, 32'd5);
        rd(8'h14, 1); chk("R9 run raised", got_a, 32'h40);
        rd(8'h14, 0); chk("R5 ns run low half", got_a, 32'h0);
        pend_id = 10'd9;
        rd(8'h0C, 1); chk("R9 equal prio refused", got_a, 32'd1023);
        pend_id = 10'd6; pend_prio = 8'h20;
        rd(8'h0C, 1); chk("R9 higher prio taken", got_a, 32'd6);
        rd(8'h14, 1); chk("R9 run now", got_a, 32'h20);

        // R10 end of interrupt
        wr(8'h10, 32'd5, 1);
        rd(8'h14, 1); chk("R10 wrong id ignored", got_a, 32'h20);
        wr(8'h10, 32'd6, 0);
        rd(8'h14, 1); chk("R10 ns eoi grp0 ignored", got_a, 32'h20);
        wr(8'h10, 32'h406, 1);
        rd(8'h14, 1); chk("R10 eoi low bits", got_a, 32'h100);

        // R5 / R9 / R10 non-secure group 1 flow
        pend_grp = 1; pend_id = 10'd100; pend_prio = 8'hC0;
        rd(8'h0C, 0); chk("R9 ns ack grp1", got_a, 32'd100);
        rd(8'h14, 0); chk("R5 ns run view", got_a, 32'h80);
        rd(8'h14, 1); chk("R5 sec run", got_a, 32'hC0);
        wr(8'h10, 32'd100, 0);
        rd(8'h14, 1); chk("R10 ns eoi grp1", got_a, 32'h100);
        pend_valid = 0;
        rd(8'h0C, 1); chk("R9 ack none", got_a, 32'd1023);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule